// File: doc/BRIEF.md
# Replicated Vector Multiply Writer

This block takes a four-lane operand x, a four-lane operand y, a replication selector and a destination register index. It forms one vec4 result in which every x lane is multiplied by the sum of all four y lanes. It then writes that vec4 into an external register file as several consecutive groups of four registers. Each lane and each register is a 32-bit integer, and all arithmetic wraps modulo 2^32.

The number of groups is a power of two set by the selector: 1 << (repSel / 32), clamped to 8. In plain mode every target register is overwritten. In accumulate mode, lanes 1 to 3 of each group are added to what the register already holds. Lane 0 of each group is overwritten and is never read. The register file is reached through one synchronous port: read data appears on `rfRdata` one cycle after the address. While `busy` is high the block ignores `start`, and `done` pulses once when the operation is finished.

Top module: `vec_scale_fanout`

## Requirements
- R1: Lane e of the result (e = 0..3; lane e sits in bits [32e+31:32e] of `xVec` and `yVec`) equals x_e * (y_0 + y_1 + y_2 + y_3), taken modulo 2^32.
- R2: For a selector value below 96, the result is written 1 << (repSel >> 5) times.
- R3: Any selector value of 96 or above gives exactly 8 groups.
- R4: Group k writes registers dst+4k to dst+4k+3 in ascending order, one register per write cycle. The address wraps modulo the register count. Any two write cycles in a row target consecutive addresses.
- R5: In accumulate mode (`accumMode`=1), lanes 1 to 3 of each group write the old register value plus the result lane.
- R6: In accumulate mode, lane 0 of each group is overwritten with the result lane and no read is issued for it. The number of reads is therefore 3 per group, and plain mode issues no reads.
- R7: In accumulate mode, each accumulated register is read (`rfRe`) in the cycle immediately before its write, at the same address. Reads and writes never coincide.
- R8: `busy` rises the cycle after an accepted `start` and stays high through the `done` cycle. A `start` seen while busy has no effect on the register file or on the timing.
- R9: `done` is a single-cycle pulse in the cycle after the final write. The count of cycles from the accepted start edge to `done` is 4N+1 in plain mode and 7N+1 in accumulate mode, where N is the number of groups.
- R10: While reset is held, `busy`, `done`, `rfWe` and `rfRe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, accepted when idle |
| accumMode | input | 1 | 1 = accumulate into existing contents |
| xVec | input | 128 | Four 32-bit x lanes, lane 0 in the low bits |
| yVec | input | 128 | Four 32-bit y lanes, summed into the scale |
| repSel | input | 32 | Replication selector |
| dstIdx | input | REG_AW | First destination register |
| rfAddr | output | REG_AW | Register file address for read or write |
| rfWe | output | 1 | Write strobe |
| rfRe | output | 1 | Read strobe; data is expected on `rfRdata` one cycle later |
| rfWdata | output | 32 | Write data |
| rfRdata | input | 32 | Synchronous read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is an accumulation whose eight groups wrap past the top of the register file and land on registers written by earlier operations. Only that case shows whether lane 0 really skips the read, and whether each read-modify-write pairs the right old value with the right address. The stimulus table runs plain and accumulate operations in sequence against a bench-side register file that is never cleared. Overlapping and wrapping destinations therefore build on earlier results, and the model tracks every register. A second start pulse is driven in the middle of an operation to show that it is ignored.

// File: rtl/vsf_pkg.sv
package vsf_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 32;
  localparam int ELEM_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_FIN
  } stateT;

  typedef struct packed {
    logic loadOps;
    logic rdStrobe;
    logic wrStrobe;
  } ctrlStrobeT;
endpackage

// File: rtl/vsf_ctrl.sv
module vsf_ctrl
  import vsf_pkg::*;
#(
  parameter int MAX_REP_LOG = 3,
  parameter int GRP_W       = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              accumMode,
  input  logic [31:0]       repSel,
  output ctrlStrobeT        strobes,
  output logic [ELEM_W-1:0] elemIdx,
  output logic [GRP_W-1:0]  grpIdx,
  output logic              busy,
  output logic              done
);
  stateT             state;
  logic [ELEM_W-1:0] elem;
  logic [GRP_W-1:0]  grp;
  logic [GRP_W-1:0]  lastGrp;
  logic [GRP_W-1:0]  lastGrpC;
  logic              accR;
  logic [26:0]       selHi;
  int unsigned       repLog;
  logic [ELEM_W-1:0] elemNext;
  logic              lastElem;

  always_comb begin
    selHi = repSel[31:5];
    if (selHi > 27'(MAX_REP_LOG)) repLog = MAX_REP_LOG;
    else                          repLog = 32'(selHi);
    lastGrpC = GRP_W'((32'd1 << repLog) - 32'd1);
  end

  assign elemNext = elem + ELEM_W'(1);
  assign lastElem = (elem == ELEM_W'(LANES - 1));

  always_comb begin
    strobes          = '0;
    strobes.loadOps  = (state == ST_IDLE) && start;
    strobes.rdStrobe = (state == ST_READ);
    strobes.wrStrobe = (state == ST_WRITE);
  end

  assign elemIdx = elem;
  assign grpIdx  = grp;
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_FIN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      elem    <= '0;
      grp     <= '0;
      lastGrp <= '0;
      accR    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_WRITE;
            elem    <= '0;
            grp     <= '0;
            lastGrp <= lastGrpC;
            accR    <= accumMode;
          end
        end
        ST_READ: state <= ST_WRITE;
        ST_WRITE: begin
          if (lastElem && (grp == lastGrp)) begin
            state <= ST_FIN;
          end else begin
            elem <= elemNext;
            if (lastElem) grp <= grp + GRP_W'(1);
            state <= (accR && (elemNext != '0)) ? ST_READ : ST_WRITE;
          end
        end
        ST_FIN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vsf_dpath.sv
module vsf_dpath
  import vsf_pkg::*;
#(
  parameter int REG_AW = 6,
  parameter int GRP_W  = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobeT               strobes,
  input  logic [ELEM_W-1:0]        elemIdx,
  input  logic [GRP_W-1:0]         grpIdx,
  input  logic [LANES*LANE_W-1:0]  xVec,
  input  logic [LANES*LANE_W-1:0]  yVec,
  input  logic                     accumMode,
  input  logic [REG_AW-1:0]        dstIdx,
  input  logic [LANE_W-1:0]        rfRdata,
  output logic [REG_AW-1:0]        rfAddr,
  output logic [LANE_W-1:0]        rfWdata
);
  logic [LANE_W-1:0] xLane [LANES];
  logic [LANE_W-1:0] prod  [LANES];
  logic [LANE_W-1:0] scaleC;
  logic [LANE_W-1:0] scaleR;
  logic [REG_AW-1:0] dstR;
  logic              accR;
  logic [LANE_W-1:0] laneVal;

  always_comb begin
    scaleC = '0;
    for (int i = 0; i < LANES; i++) scaleC = scaleC + yVec[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LANES; i++) xLane[i] <= '0;
      scaleR <= '0;
      dstR   <= '0;
      accR   <= 1'b0;
    end else if (strobes.loadOps) begin
      for (int i = 0; i < LANES; i++) xLane[i] <= xVec[i*LANE_W +: LANE_W];
      scaleR <= scaleC;
      dstR   <= dstIdx;
      accR   <= accumMode;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign prod[i] = xLane[i] * scaleR;
  end

  assign laneVal = prod[elemIdx];
  assign rfAddr  = dstR + REG_AW'({grpIdx, elemIdx});
  assign rfWdata = (accR && (elemIdx != '0)) ? (rfRdata + laneVal) : laneVal;
endmodule

// File: rtl/vec_scale_fanout.sv
module vec_scale_fanout
  import vsf_pkg::*;
#(
  parameter int REG_AW      = 6,
  parameter int MAX_REP_LOG = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    accumMode,
  input  logic [LANES*LANE_W-1:0] xVec,
  input  logic [LANES*LANE_W-1:0] yVec,
  input  logic [31:0]             repSel,
  input  logic [REG_AW-1:0]       dstIdx,
  output logic [REG_AW-1:0]       rfAddr,
  output logic                    rfWe,
  output logic                    rfRe,
  output logic [LANE_W-1:0]       rfWdata,
  input  logic [LANE_W-1:0]       rfRdata,
  output logic                    busy,
  output logic                    done
);
  localparam int GRP_W = (MAX_REP_LOG > 0) ? MAX_REP_LOG : 1;

  ctrlStrobeT        strobes;
  logic [ELEM_W-1:0] elemIdx;
  logic [GRP_W-1:0]  grpIdx;

  vsf_ctrl #(.MAX_REP_LOG(MAX_REP_LOG), .GRP_W(GRP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .accumMode(accumMode),
    .repSel(repSel), .strobes(strobes), .elemIdx(elemIdx),
    .grpIdx(grpIdx), .busy(busy), .done(done)
  );

  vsf_dpath #(.REG_AW(REG_AW), .GRP_W(GRP_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .elemIdx(elemIdx),
    .grpIdx(grpIdx), .xVec(xVec), .yVec(yVec), .accumMode(accumMode),
    .dstIdx(dstIdx), .rfRdata(rfRdata), .rfAddr(rfAddr), .rfWdata(rfWdata)
  );

  assign rfWe = strobes.wrStrobe;
  assign rfRe = strobes.rdStrobe;
endmodule

// File: rtl/vsf_checker.sv
module vsf_checker #(
  parameter int REG_AW = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [REG_AW-1:0] rfAddr,
  input logic              rfWe,
  input logic              rfRe,
  input logic              busy,
  input logic              done
);
  assert_no_rw_overlap_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(rfWe && rfRe));

  assert_read_then_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    rfRe |=> (rfWe && $stable(rfAddr)));

  assert_lane0_no_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    rfRe |-> ($past(rfWe) && (rfAddr == REG_AW'($past(rfAddr) + 1'b1))));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rfWe && $past(rfWe)) |-> (rfAddr == REG_AW'($past(rfAddr) + 1'b1)));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!rfWe && !rfRe));

  assert_done_in_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_after_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(rfWe));

  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rstN |=> (!busy && !done && !rfWe && !rfRe));
endmodule

bind vec_scale_fanout vsf_checker #(.REG_AW(REG_AW)) u_vsf_checker (
  .clk(clk), .rstN(rstN), .rfAddr(rfAddr), .rfWe(rfWe), .rfRe(rfRe),
  .busy(busy), .done(done)
);

// File: tb/vec_scale_fanout_bench.sv
`timescale 1ns/1ps
module vec_scale_fanout_bench;
  localparam int AW   = 6;
  localparam int NREG = 1 << AW;

  typedef struct packed {
    logic [127:0] x;
    logic [127:0] y;
    logic [31:0]  sel;
    logic [5:0]   dst;
    logic         acc;
  } vecT;

  localparam vecT TBL [7] = '{
    '{128'h00000004_00000003_00000002_00000001, 128'h00000001_00000001_00000001_00000001, 32'd0,   6'd0,  1'b0},
    '{128'h00000008_00000007_00000006_00000005, 128'h00000001_00000000_00000000_00000002, 32'd32,  6'd10, 1'b0},
    '{128'h00000001_00000001_00000001_00000001, 128'h00000000_00000000_00000000_0000000A, 32'd64,  6'd20, 1'b1},
    '{128'h00000003_FFFFFFFF_00000010_00000002, 128'h00000000_00000000_00000001_00000001, 32'd100, 6'd60, 1'b1},
    '{128'h00000000_00000000_00000007_FFFFFFFF, 128'h00000000_00000001_80000000_80000000, 32'd31,  6'd5,  1'b0},
    '{128'h00000009_00000007_00010000_00010000, 128'h00000001_00010000_00000000_00000000, 32'hFFFFFFE0, 6'd33, 1'b0},
    '{128'h00000002_00000002_00000002_00000002, 128'h00000003_00000000_00000000_00000000, 32'd96,  6'd2,  1'b1}
  };

  logic          clk = 1'b0;
  logic          rstN;
  logic          start;
  logic          accumMode;
  logic [127:0]  xVec;
  logic [127:0]  yVec;
  logic [31:0]   repSel;
  logic [AW-1:0] dstIdx;
  logic [AW-1:0] rfAddr;
  logic          rfWe;
  logic          rfRe;
  logic [31:0]   rfWdata;
  logic [31:0]   rfRdata;
  logic          busy;
  logic          done;

  always #2 clk = ~clk;

  vec_scale_fanout #(.REG_AW(AW), .MAX_REP_LOG(3)) u_vec_scale_fanout (
    .clk(clk), .rstN(rstN), .start(start), .accumMode(accumMode),
    .xVec(xVec), .yVec(yVec), .repSel(repSel), .dstIdx(dstIdx),
    .rfAddr(rfAddr), .rfWe(rfWe), .rfRe(rfRe), .rfWdata(rfWdata),
    .rfRdata(rfRdata), .busy(busy), .done(done)
  );

  logic [31:0]   rf    [NREG];
  logic [31:0]   expRf [NREG];
  logic [AW-1:0] wrLog [64];
  int            wrCnt;
  int            rdCnt;
  int            nChecks = 0;
  int            nFail   = 0;

  always @(posedge clk) begin
    rfRdata <= rf[rfAddr];
    if (rfWe) rf[rfAddr] <= rfWdata;
  end

  always @(negedge clk) begin
    if (rfWe) begin
      if (wrCnt < 64) wrLog[wrCnt] = rfAddr;
      wrCnt = wrCnt + 1;
    end
    if (rfRe) rdCnt = rdCnt + 1;
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  // Runs one operation; pokeAt > 0 drives a second start in that cycle (R8).
  task automatic runOp(input vecT v, input int pokeAt, input string tag);
    int unsigned   sh;
    int            reps;
    logic [31:0]   sc;
    logic [31:0]   lv;
    logic [AW-1:0] a;
    logic [AW-1:0] expLog [64];
    int            n;
    int            cycles;
    int            busyLow;
    int            bad;
    logic          logOk;
    sh   = v.sel >> 5;
    reps = (sh >= 3) ? 8 : (1 << sh);
    sc   = v.y[31:0] + v.y[63:32] + v.y[95:64] + v.y[127:96];
    n    = 0;
    for (int g = 0; g < reps; g++) begin
      for (int e = 0; e < 4; e++) begin
        a  = AW'(v.dst + AW'(4*g + e));
        lv = v.x[e*32 +: 32] * sc;
        expRf[a] = (v.acc && e != 0) ? expRf[a] + lv : lv;
        expLog[n] = a;
        n++;
      end
    end
    @(negedge clk);
    wrCnt = 0; rdCnt = 0;
    xVec = v.x; yVec = v.y; repSel = v.sel; dstIdx = v.dst; accumMode = v.acc;
    start = 1'b1;
    cycles = 0; busyLow = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      cycles++;
      if (!busy) busyLow++;
      if (cycles == pokeAt) begin
        start = 1'b1; dstIdx = v.dst + 6'd16; accumMode = ~v.acc; repSel = 32'd0;
      end
    end while (!done && cycles < 200);
    start = 1'b0;
    chk(cycles == (v.acc ? 7 : 4) * reps + 1, "R9 R2 R3", {tag, " latency"},
        32'(cycles), 32'((v.acc ? 7 : 4) * reps + 1));
    chk(busyLow == 0, "R8", {tag, " busy dropped"}, 32'(busyLow), 32'd0);
    logOk = (wrCnt == n);
    for (int i = 0; i < n && i < 64; i++) if (wrLog[i] !== expLog[i]) logOk = 1'b0;
    chk(logOk, "R4", {tag, " write order/count"}, 32'(wrCnt), 32'(n));
    chk(rdCnt == (v.acc ? 3 * reps : 0), "R6 R7", {tag, " read count"},
        32'(rdCnt), 32'(v.acc ? 3 * reps : 0));
    @(negedge clk);
    bad = -1;
    for (int i = 0; i < NREG; i++) if (bad < 0 && rf[i] !== expRf[i]) bad = i;
    chk(bad < 0, "R1 R5 R6", {tag, " register contents"},
        (bad < 0) ? 32'd0 : rf[bad], (bad < 0) ? 32'd0 : expRf[bad]);
    chk(!busy && !done, "R9", {tag, " done single pulse"}, {30'd0, busy, done}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    rstN = 1'b0; start = 1'b0; accumMode = 1'b0; xVec = '0; yVec = '0;
    repSel = '0; dstIdx = '0;
    wrCnt = 0; rdCnt = 0;
    for (int i = 0; i < NREG; i++) begin
      rf[i]    = 32'h1000_0000 + 32'(i * 3);
      expRf[i] = 32'h1000_0000 + 32'(i * 3);
    end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rfWe && !rfRe, "R10", "reset outputs",
        {28'd0, busy, done, rfWe, rfRe}, 32'd0);
    @(negedge clk) rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done, "R10", "idle after reset", {30'd0, busy, done}, 32'd0);

    for (int k = 0; k < 7; k++) runOp(TBL[k], 0, $sformatf("vec%0d", k));

    // Start pulsed mid-operation must be ignored (R8)
    runOp('{128'h00000005_00000004_00000003_00000002,
            128'h00000000_00000000_00000000_00000003, 32'd32, 6'd40, 1'b0},
          3, "busy-start");
    runOp('{128'h00000001_00000002_00000003_00000004,
            128'h00000000_00000001_00000000_00000001, 32'd40, 6'd62, 1'b1},
          5, "busy-start-acc");
    finishRun();
  end
endmodule